// File: doc/BRIEF.md
# Card Session Activation Sequencer

This block powers a contact smart card up and down in a fixed, timed order. It turns a session command, a reset request, a card-present contact and a set of digital fault flags into the enables for the card supply converter, the card supply, the I/O lines, the card clock and the card reset. It also drives a status flag back to the host. One clock drives the whole block: the internal oscillator. Time is measured in units T of `OSC_PER_T` oscillator periods, and the sequencer moves in half-T steps.

A session opens when the command input goes low while a debounced card is present. The block then climbs through the activation steps. It leaves the active state through the same steps in reverse, either when the command returns high or at once when any fault appears, including card removal. The reset request does two jobs. During activation it can hold back the card clock so that the host can count clock pulses exactly. After activation it is passed straight to the card reset contact.

Top module: `card_seq_top`

## Requirements
- R1: While rst_ni is low, every output is low.
- R2: In the edge that sees cmd_n_i low with a debounced card present and the block idle, conv_en_o, osc_fast_o and vcc_en_o go high. With no card present, a low command does nothing.
- R3: io_en_o goes high 8 half-T steps (4T) after the session-start edge. Half-T equals OSC_PER_T/2 oscillator cycles.
- R4: If rst_req_i is low at session start, clk_en_o goes high in the same edge as io_en_o.
- R5: If rst_req_i is high at session start, clk_en_o goes high in the edge after rst_req_i is first seen low, but never before the edge after io_en_o rises. If rst_req_i is still high at reset enable, the clock starts at reset enable.
- R6: At 14 half-T steps (7T) after session start, reset is enabled. From then on card_rst_o equals rst_req_i combinationally and rst_req_i no longer changes clk_en_o. card_rst_o is never high while clk_en_o is low.
- R7: Deactivation starts in the edge that sees cmd_n_i high during a session. In that edge card_rst_o goes low. clk_en_o goes low one half-T later, io_en_o two half-T later, vcc_en_o three half-T later, and conv_en_o with osc_fast_o ten half-T (5T) later. io_en_o implies vcc_en_o and clk_en_o implies io_en_o at all times.
- R8: Any of the fault inputs (overcurrent, overheating, supply low, converter out of range) during a session drives status_o low in the next edge and starts the deactivation of R7.
- R9: status_o rises only after pres_i has been high for DEB_CYC consecutive edges. It falls in the edge after pres_i goes low. A drop of pres_i during a session starts deactivation at once.
- R10: Outside a session, flt_uv_i has no effect on status_o or on the enables.
- R11: After reset, and after a deactivation, a low cmd_n_i is ignored until cmd_n_i has been seen high. A fault-forced low status_o stays low until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_n_i | input | 1 | Session command, low requests a session |
| rst_req_i | input | 1 | Reset request from host |
| pres_i | input | 1 | Raw card-present contact, high when present |
| flt_ovc_i | input | 1 | Card supply overcurrent flag |
| flt_hot_i | input | 1 | Overheating flag |
| flt_uv_i | input | 1 | Host supply low flag |
| flt_conv_i | input | 1 | Converter out of range flag |
| conv_en_o | output | 1 | Supply converter enable |
| osc_fast_o | output | 1 | Internal oscillator high-rate select |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Card I/O enable, low holds lines low |
| clk_en_o | output | 1 | Card clock enable |
| card_rst_o | output | 1 | Card reset contact |
| status_o | output | 1 | Status flag to host |

## Verification
The assertions check the ordering relations on every cycle. The I/O enable never runs ahead of the supply, the clock never runs ahead of the I/O lines, and card reset only follows the request while the clock runs. A removed card always clears status within one edge, and status holds while idle with a card present. The exact half-T positions of each activation and deactivation step, and the several ways the reset request can gate the clock start, only show up in the bench's timed scenarios. The same holds for the debounce length, the fault latch and its release, and the rule that a command held low must first be seen high.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_ON,
    ST_DEACT,
    ST_WAIT
  } seq_st_e;
endpackage

// File: rtl/card_seq_tick.sv
module card_seq_tick #(
  parameter int HALF = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/card_seq_debounce.sv
module card_seq_debounce #(
  parameter int DEB_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pres_i,
  output logic stable_o
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt_q;

  // rise needs a full quiet window, fall is immediate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_o <= 1'b0;
    end else if (!pres_i) begin
      cnt_q    <= '0;
      stable_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      stable_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
  import card_seq_pkg::*;
#(
  parameter int IO_STEP  = 8,
  parameter int RST_STEP = 14,
  parameter int CLK_OFF  = 1,
  parameter int IO_OFF   = 2,
  parameter int VCC_OFF  = 3,
  parameter int CONV_OFF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cmd_n_i,
  input  logic rst_req_i,
  input  logic pres_db_i,
  input  logic fault_i,
  output logic clr_o,
  output logic conv_o,
  output logic osc_o,
  output logic vcc_o,
  output logic io_o,
  output logic clk_o,
  output logic rst_live_o,
  output logic flt_o
);
  localparam int MAXS = (RST_STEP > CONV_OFF) ? RST_STEP : CONV_OFF;
  localparam int SW   = $clog2(MAXS + 1);

  seq_st_e st_q;
  logic [SW-1:0] step_q;
  logic rq_start_q;
  logic start_go, deact_go;

  assign start_go = (st_q == ST_IDLE) && !cmd_n_i && pres_db_i;
  assign deact_go = ((st_q == ST_ACT) || (st_q == ST_ON)) && (cmd_n_i || fault_i);
  assign clr_o    = (st_q == ST_IDLE) || (st_q == ST_WAIT) || (st_q == ST_ON) || deact_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_WAIT;   // command must be seen high first
      step_q     <= '0;
      rq_start_q <= 1'b0;
      conv_o     <= 1'b0;
      osc_o      <= 1'b0;
      vcc_o      <= 1'b0;
      io_o       <= 1'b0;
      clk_o      <= 1'b0;
      rst_live_o <= 1'b0;
      flt_o      <= 1'b0;
    end else if (deact_go) begin
      st_q       <= ST_DEACT;
      step_q     <= '0;
      rst_live_o <= 1'b0;
      if (fault_i) flt_o <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: if (start_go) begin
          st_q       <= ST_ACT;
          step_q     <= '0;
          rq_start_q <= rst_req_i;
          conv_o     <= 1'b1;
          osc_o      <= 1'b1;
          vcc_o      <= 1'b1;
        end
        ST_ACT: begin
          if (tick_i) begin
            step_q <= step_q + 1'b1;
            if (step_q == SW'(IO_STEP - 1)) begin
              io_o <= 1'b1;
              if (!rq_start_q) clk_o <= 1'b1;
            end
            if (step_q == SW'(RST_STEP - 1)) begin
              st_q       <= ST_ON;
              rst_live_o <= 1'b1;
              clk_o      <= 1'b1;
            end
          end
          // held-off clock released by the reset request falling
          if (io_o && !rst_req_i) clk_o <= 1'b1;
        end
        ST_DEACT: if (tick_i) begin
          step_q <= step_q + 1'b1;
          if (step_q == SW'(CLK_OFF - 1)) clk_o <= 1'b0;
          if (step_q == SW'(IO_OFF - 1))  io_o  <= 1'b0;
          if (step_q == SW'(VCC_OFF - 1)) vcc_o <= 1'b0;
          if (step_q == SW'(CONV_OFF - 1)) begin
            conv_o <= 1'b0;
            osc_o  <= 1'b0;
            st_q   <= ST_WAIT;
          end
        end
        ST_WAIT: if (cmd_n_i) begin
          st_q  <= ST_IDLE;
          flt_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/card_seq_top.sv
module card_seq_top #(
  parameter int OSC_PER_T = 64,
  parameter int DEB_CYC   = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_n_i,
  input  logic rst_req_i,
  input  logic pres_i,
  input  logic flt_ovc_i,
  input  logic flt_hot_i,
  input  logic flt_uv_i,
  input  logic flt_conv_i,
  output logic conv_en_o,
  output logic osc_fast_o,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic card_rst_o,
  output logic status_o
);
  localparam int HALF = OSC_PER_T / 2;

  logic tick, clr, pres_db, fault, rst_live, flt_q;

  assign fault = flt_ovc_i | flt_hot_i | flt_uv_i | flt_conv_i | !pres_i;

  card_seq_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_o(tick)
  );

  card_seq_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pres_i  (pres_i),
    .stable_o(pres_db)
  );

  card_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cmd_n_i   (cmd_n_i),
    .rst_req_i (rst_req_i),
    .pres_db_i (pres_db),
    .fault_i   (fault),
    .clr_o     (clr),
    .conv_o    (conv_en_o),
    .osc_o     (osc_fast_o),
    .vcc_o     (vcc_en_o),
    .io_o      (io_en_o),
    .clk_o     (clk_en_o),
    .rst_live_o(rst_live),
    .flt_o     (flt_q)
  );

  assign card_rst_o = rst_live & rst_req_i;
  assign status_o   = !flt_q && pres_db;
endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_n_i,
  input logic rst_req_i,
  input logic pres_i,
  input logic flt_uv_i,
  input logic conv_en_o,
  input logic vcc_en_o,
  input logic io_en_o,
  input logic clk_en_o,
  input logic card_rst_o,
  input logic status_o
);
  a_r7_io_needs_vcc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> vcc_en_o);

  a_r7_clk_needs_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> io_en_o);

  a_r2_vcc_needs_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_en_o |-> conv_en_o);

  a_r6_rst_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_o |-> (rst_req_i && clk_en_o));

  a_r9_removal_drops_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pres_i |=> !status_o);

  a_r10_idle_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_en_o && $past(!conv_en_o) && $past(pres_i) && $past(status_o)) |-> status_o);
endmodule

bind card_seq_top card_seq_chk u_chk (.*);

// File: tb/tb_card_seq_top.sv
`timescale 1ns/1ps
module tb_card_seq_top;
  localparam int OPT = 16;
  localparam int H   = OPT / 2;
  localparam int DEB = 40;
  localparam int NV  = 6;
  // vector table: rst_req level at start, cycle index at which it is released
  localparam int V_RQ  [NV] = '{0, 1, 1, 1, 1, 1};
  localparam int V_REL [NV] = '{0, 5, 8*H, 8*H+10, 14*H, 200};

  logic clk = 0, rst_ni = 0;
  logic cmd_n = 0, rst_req = 0, pres = 0;
  logic f_ovc = 0, f_hot = 0, f_uv = 0, f_conv = 0;
  logic conv_en, osc_fast, vcc_en, io_en, clk_en, card_rst, status;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  card_seq_top #(.OSC_PER_T(OPT), .DEB_CYC(DEB)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_n_i(cmd_n), .rst_req_i(rst_req),
    .pres_i(pres), .flt_ovc_i(f_ovc), .flt_hot_i(f_hot), .flt_uv_i(f_uv),
    .flt_conv_i(f_conv), .conv_en_o(conv_en), .osc_fast_o(osc_fast),
    .vcc_en_o(vcc_en), .io_en_o(io_en), .clk_en_o(clk_en),
    .card_rst_o(card_rst), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int exp_clk(input int rq, input int rel);
    int e;
    if (rq == 0) return 1 + 8*H;
    e = (rel + 1 > 8*H + 2) ? rel + 1 : 8*H + 2;
    return (e < 14*H + 1) ? e : 14*H + 1;
  endfunction

  task automatic deact_check();
    int f_rst = -1, f_clk = -1, f_io = -1, f_vcc = -1, f_conv = -1;
    for (int k = 1; k <= 10*H + 2; k++) begin
      cyc();
      if (f_rst  < 0 && !card_rst) f_rst  = k;
      if (f_clk  < 0 && !clk_en)   f_clk  = k;
      if (f_io   < 0 && !io_en)    f_io   = k;
      if (f_vcc  < 0 && !vcc_en)   f_vcc  = k;
      if (f_conv < 0 && !conv_en && !osc_fast) f_conv = k;
    end
    chk(f_rst  == 1,        "R7 reset low",   f_rst,  1);
    chk(f_clk  == 1 + H,    "R7 clock off",   f_clk,  1 + H);
    chk(f_io   == 1 + 2*H,  "R7 io off",      f_io,   1 + 2*H);
    chk(f_vcc  == 1 + 3*H,  "R7 supply off",  f_vcc,  1 + 3*H);
    chk(f_conv == 1 + 10*H, "R7 converter off", f_conv, 1 + 10*H);
  endtask

  task automatic run_vec(input int rq, input int rel);
    int f_io = -1, f_clk = -1, ec;
    rst_req = rq[0]; cmd_n = 0;
    for (int k = 1; k <= 14*H + 2; k++) begin
      cyc();
      if (k == 1) chk(conv_en && osc_fast && vcc_en, "R2 start enables", vcc_en, 1);
      if (f_io  < 0 && io_en)  f_io  = k;
      if (f_clk < 0 && clk_en) f_clk = k;
      if (rq != 0 && k == rel) rst_req = 0;
    end
    ec = exp_clk(rq, rel);
    chk(f_io == 1 + 8*H, "R3 io enable time", f_io, 1 + 8*H);
    if (rq == 0) chk(f_clk == ec, "R4 clock with io", f_clk, ec);
    else         chk(f_clk == ec, "R5 gated clock start", f_clk, ec);
    rst_req = 1; #1;
    chk(card_rst == 1, "R6 reset copies high", card_rst, 1);
    rst_req = 0; #1;
    chk(card_rst == 0 && clk_en == 1, "R6 reset copies low, clock kept", card_rst, 0);
    @(negedge clk);
    rst_req = 1; cmd_n = 1;
    deact_check();
    rst_req = 0;
    cyc(); cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f_st;
    #11;
    chk(!conv_en && !osc_fast && !vcc_en && !io_en && !clk_en && !card_rst && !status,
        "R1 reset state", status, 0);
    @(negedge clk); rst_ni = 1;
    // debounce while command held low since reset
    pres = 1; f_st = -1;
    for (int k = 1; k <= DEB + 2; k++) begin
      cyc();
      if (f_st < 0 && status) f_st = k;
    end
    chk(f_st == DEB, "R9 debounce rise", f_st, DEB);
    chk(!conv_en, "R11 command low from reset ignored", conv_en, 0);
    cmd_n = 1; cyc(); cyc();
    f_uv = 1; cyc(); cyc(); cyc();
    chk(status && !conv_en && !vcc_en, "R10 supply low idle no effect", status, 1);
    f_uv = 0; cyc();

    for (int i = 0; i < NV; i++) run_vec(V_RQ[i], V_REL[i]);

    // fault in active session
    cmd_n = 0;
    for (int k = 0; k < 14*H + 3; k++) cyc();
    f_hot = 1; cyc(); f_hot = 0;
    chk(!status && conv_en, "R8 fault drops status", status, 0);
    f_st = -1;
    for (int k = 2; k <= 10*H + 2; k++) begin
      cyc();
      if (f_st < 0 && !conv_en) f_st = k;
    end
    chk(f_st == 1 + 10*H, "R8 fault deactivation", f_st, 1 + 10*H);
    for (int k = 0; k < 5; k++) cyc();
    chk(!conv_en && !status, "R11 relaunch blocked, status held", status, 0);
    cmd_n = 1; cyc();
    chk(status == 1, "R11 status restored after command high", status, 1);
    cyc();

    // card removal during activation
    cmd_n = 0;
    for (int k = 0; k < 20; k++) cyc();
    pres = 0; cyc();
    chk(!status, "R9 removal drops status", status, 0);
    f_st = -1;
    for (int k = 2; k <= 10*H + 2; k++) begin
      cyc();
      if (f_st < 0 && !conv_en) f_st = k;
    end
    chk(f_st == 1 + 10*H, "R9 removal deactivation", f_st, 1 + 10*H);
    cmd_n = 1; cyc(); cyc();

    // no card: command ignored
    cmd_n = 0;
    for (int k = 0; k < 6; k++) cyc();
    chk(!conv_en && !vcc_en, "R2 no card no start", conv_en, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule